// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block adds or subtracts two IEEE-754 single-precision numbers in a fixed three-register pipeline. A new operation can enter on every clock. The operation is marked by a valid strobe. Each operation carries its own 2-bit rounding-mode code. The result, an overflow flag and an underflow flag appear together with an output valid strobe exactly three clock edges after the operation was accepted.

The first register stage compares the two magnitudes and swaps the operands so that the larger one comes first. It then shifts the smaller significand right by the exponent difference. Guard, round and sticky positions keep every bit that is shifted out. The second stage adds or subtracts the aligned significands. The choice depends on the requested operation and the two signs. A carry out of this sum shifts the significand right by one and moves the exponent up by one in the same stage. The third stage runs a leading-one search on the finished sum, shifts the significand left and lowers the exponent to match. It then rounds the result, fixes up a carry caused by rounding, and applies the overflow and underflow rules. The leading-one position is found only after the sum is complete; it is not predicted in parallel with the sum.

Top module: `fpa_top`

## Requirements
- R1: An operation accepted with `in_vld` high at a rising edge appears on `result`, `ovf` and `unf`, with `out_vld` high, after exactly three rising edges. Back-to-back operations are accepted on every clock. `ovf` and `unf` are low whenever `out_vld` is low.
- R2: For operands with exponent fields 1 to 254, `result` is the correctly rounded value of `op_a + op_b` when `op_sub` is 0, and of `op_a - op_b` when `op_sub` is 1. The sign is taken from the operand with the larger magnitude.
- R3: `in_rm` selects the rounding mode: 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward plus infinity, and 11 rounds toward minus infinity. In mode 01 the exponent field of the result is never 255.
- R4: When the exponents differ by more than the significand width, the smaller operand still decides the rounding direction through the sticky bit. Example: 1.0 + 2^-40 gives 0x3F800001 in mode 10 and 0x3F800000 in mode 00.
- R5: When the aligned significand sum carries out, the result is renormalized and the exponent is incremented. Example: 1.5 + 1.5 gives 0x40400000.
- R6: When a subtraction cancels leading bits, the result is shifted left to the first one and the exponent is reduced by the same amount.
- R7: When rounding carries out of the significand, the result moves to the next binade and gets a zero fraction.
- R8: When the rounded biased exponent is 255 or more, `ovf` is set. The result is infinity (exponent 255, fraction 0) in mode 00, in mode 10 for a positive result and in mode 11 for a negative result. Otherwise the result is the largest finite value (exponent 254, all-ones fraction) with the result's sign. `ovf` implies an exponent field of 254 or 255, and `unf` is never set together with `ovf`.
- R9: When the normalized biased exponent before rounding is below 1, `unf` is set and the result is a zero that keeps the result sign.
- R10: An exactly zero sum gives +0 (0x00000000) with no flags, except in mode 11, where it gives -0 (0x80000000).
- R11: An operand whose exponent field is 0 is treated as zero, whatever its fraction holds.
- R12: While reset is high and after it is released, before any operation, `out_vld`, `result`, `ovf` and `unf` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation valid |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| op_sub | input | 1 | 1 subtracts op_b, 0 adds it |
| in_rm | input | 2 | Rounding mode code (see R3) |
| out_vld | output | 1 | Result valid |
| result | output | 32 | Rounded sum or difference |
| ovf | output | 1 | Exponent overflow, result saturated |
| unf | output | 1 | Exponent underflow, result flushed to zero |

## Verification
The hardest situations to reach are the two corrections that chain inside the last stage. One is a rounding carry that lands exactly at the overflow boundary. The other is a deep cancellation that drops the exponent below 1 only after the left shift. Random operands almost never produce either one. The stimulus therefore places them directly: operand pairs at the top of the exponent range in every rounding mode, all-ones significands pushed up by a sticky contribution, and pairs of minimum-exponent numbers that differ in the last bit. A long random stream then follows. In that stream the second exponent is usually kept within a few steps of the first, so cancellation and carry happen often. All results are compared against an exact wide-integer model of the sum.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int EW  = 8;
    localparam int FW  = 23;
    localparam int WW  = 1 + EW + FW;
    localparam int MW  = FW + 1;
    localparam int XW  = MW + 3;
    localparam int LZW = $clog2(XW + 1);
    localparam int EMAX = (1 << EW) - 1;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic          vld;
        logic          sgn_l;
        logic          sgn_s;
        logic [EW-1:0] exp;
        logic [XW-1:0] big;
        logic [XW-1:0] sml;
        rmode_e        rm;
    } s1_t;

    typedef struct packed {
        logic                 vld;
        logic                 sgn;
        logic signed [EW+1:0] exp;
        logic [XW-1:0]        mant;
        rmode_e               rm;
    } s2_t;

    typedef struct packed {
        logic          vld;
        logic [WW-1:0] res;
        logic          ovf;
        logic          unf;
    } s3_t;

    // right shift keeping every lost bit in the lowest (sticky) position
    function automatic logic [XW-1:0] align_rs(input logic [XW-1:0] m, input logic [EW-1:0] d);
        logic [XW-1:0] sh;
        logic [XW-1:0] lost;
        if (int'(d) >= XW)
            return {{(XW-1){1'b0}}, |m};
        sh   = m >> d;
        lost = m & ~({XW{1'b1}} << d);
        return {sh[XW-1:1], sh[0] | (|lost)};
    endfunction

    function automatic logic [LZW-1:0] lead_zeros(input logic [XW-1:0] m);
        logic [LZW-1:0] n;
        n = LZW'(XW);
        for (int i = 0; i < XW; i++)
            if (m[i]) n = LZW'(XW - 1 - i);
        return n;
    endfunction
endpackage

// File: rtl/fpa_align.sv
module fpa_align
    import fpa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [WW-1:0] op_a,
    input  logic [WW-1:0] op_b,
    input  logic          op_sub,
    input  logic [1:0]    in_rm,
    output s1_t           q
);
    logic [EW-1:0] ea, eb, el, es;
    logic [MW-1:0] ma, mb, ml, ms;
    logic [EW+FW-1:0] ka, kb;
    logic sa, sb, swap;
    s1_t d;

    always_comb begin
        ea = op_a[WW-2 -: EW];
        eb = op_b[WW-2 -: EW];
        sa = op_a[WW-1];
        sb = op_b[WW-1] ^ op_sub;
        ma = (ea == '0) ? '0 : {1'b1, op_a[FW-1:0]};
        mb = (eb == '0) ? '0 : {1'b1, op_b[FW-1:0]};
        ka = {ea, ma[FW-1:0]};
        kb = {eb, mb[FW-1:0]};
        swap = kb > ka;
        el = swap ? eb : ea;
        es = swap ? ea : eb;
        ml = swap ? mb : ma;
        ms = swap ? ma : mb;
        d.vld   = in_vld;
        d.sgn_l = swap ? sb : sa;
        d.sgn_s = swap ? sa : sb;
        d.exp   = el;
        d.big   = {ml, 3'b000};
        d.sml   = align_rs({ms, 3'b000}, el - es);
        d.rm    = rmode_e'(in_rm);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
    import fpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  p,
    output s2_t  q
);
    logic [XW:0] sum;
    logic        cy;
    s2_t d;

    always_comb begin
        if (p.sgn_l ^ p.sgn_s) sum = {1'b0, p.big} - {1'b0, p.sml};
        else                   sum = {1'b0, p.big} + {1'b0, p.sml};
        cy = sum[XW];
        d.vld  = p.vld;
        d.sgn  = p.sgn_l;
        d.rm   = p.rm;
        d.exp  = $signed({2'b00, p.exp} + {{(EW+1){1'b0}}, cy});
        d.mant = cy ? {sum[XW:2], sum[1] | sum[0]} : sum[XW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/fpa_round.sv
module fpa_round
    import fpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s2_t  p,
    output s3_t  q
);
    logic [LZW-1:0]       lz;
    logic [XW-1:0]        norm;
    logic signed [EW+1:0] en, er;
    logic                 g, rest, lsb, inexact, up, to_inf;
    logic [MW:0]          mr;
    logic [FW-1:0]        frac;
    s3_t d;

    always_comb begin
        lz   = lead_zeros(p.mant);
        norm = p.mant << lz;
        en   = p.exp - $signed({{(EW+2-LZW){1'b0}}, lz});
        lsb  = norm[3];
        g    = norm[2];
        rest = |norm[1:0];
        inexact = g | rest;
        unique case (p.rm)
            RM_NEAR: up = g & (rest | lsb);
            RM_ZERO: up = 1'b0;
            RM_UP:   up = inexact & ~p.sgn;
            default: up = inexact & p.sgn;
        endcase
        mr   = {1'b0, norm[XW-1:3]} + {{MW{1'b0}}, up};
        er   = en + $signed({{(EW+1){1'b0}}, mr[MW]});
        frac = mr[MW] ? mr[FW:1] : mr[FW-1:0];
        to_inf = (p.rm == RM_NEAR) || (p.rm == RM_UP && !p.sgn) || (p.rm == RM_DOWN && p.sgn);

        d.vld = p.vld;
        d.ovf = 1'b0;
        d.unf = 1'b0;
        if (p.mant == '0) begin
            d.res = {p.rm == RM_DOWN, {(WW-1){1'b0}}};
        end else if (en < 1) begin
            d.res = {p.sgn, {(WW-1){1'b0}}};
            d.unf = p.vld;
        end else if (er >= EMAX) begin
            d.ovf = p.vld;
            d.res = to_inf ? {p.sgn, {EW{1'b1}}, {FW{1'b0}}}
                           : {p.sgn, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
        end else begin
            d.res = {p.sgn, er[EW-1:0], frac};
        end
        if (!p.vld) d.res = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/fpa_top.sv
module fpa_top
    import fpa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [WW-1:0] op_a,
    input  logic [WW-1:0] op_b,
    input  logic          op_sub,
    input  logic [1:0]    in_rm,
    output logic          out_vld,
    output logic [WW-1:0] result,
    output logic          ovf,
    output logic          unf
);
    s1_t st1;
    s2_t st2;
    s3_t st3;

    fpa_align u_align (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .in_rm(in_rm), .q(st1)
    );

    fpa_addsub u_addsub (.clk(clk), .rst(rst), .p(st1), .q(st2));

    fpa_round u_round (.clk(clk), .rst(rst), .p(st2), .q(st3));

    assign out_vld = st3.vld;
    assign result  = st3.res;
    assign ovf     = st3.ovf;
    assign unf     = st3.unf;
endmodule

// File: rtl/fpa_chk.sv
module fpa_chk
    import fpa_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic [1:0]    in_rm,
    input logic          out_vld,
    input logic [WW-1:0] result,
    input logic          ovf,
    input logic          unf
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= 2'd0;
        else if (age != 3) age <= age + 2'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    assert_flags_gated_R1: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (!ovf && !unf));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));

    assert_ovf_exp_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (result[WW-2 -: EW] >= EW'(EMAX - 1)));

    assert_no_inf_R8: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !ovf) |-> (result[WW-2 -: EW] != EW'(EMAX)));

    assert_unf_zero_R9: assert property (@(posedge clk) disable iff (rst)
        unf |-> (result[WW-2:0] == '0));

    assert_rtz_finite_R3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_vld && $past(in_rm, 3) == 2'b01) |-> (result[WW-2 -: EW] != EW'(EMAX)));
endmodule

bind fpa_top fpa_chk u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rm(in_rm),
    .out_vld(out_vld), .result(result), .ovf(ovf), .unf(unf)
);

// File: tb/sim_fpa_top.sv
`timescale 1ns/1ps
module sim_fpa_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        op_sub = 1'b0;
    logic [1:0]  in_rm = 2'b00;
    logic        out_vld, ovf, unf;
    logic [31:0] result;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R2";

    logic [33:0] exp_r [3];
    logic        exp_v [3];
    string       exp_t [3];

    always #2.5 clk = ~clk;

    fpa_top u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .in_rm(in_rm), .out_vld(out_vld), .result(result),
        .ovf(ovf), .unf(unf)
    );

    // exact reference: both operands placed in one wide integer, then rounded
    function automatic logic [33:0] ref_add(logic [31:0] a, logic [31:0] b, logic sub, logic [1:0] rm);
        logic [299:0] va, vb, mag, low;
        logic sa, sb, s, g, up, inexact, to_inf;
        int ea, eb, p, e;
        logic [24:0] keep;
        ea = int'(a[30:23]); eb = int'(b[30:23]);
        sa = a[31]; sb = b[31] ^ sub;
        va = '0; vb = '0;
        if (ea != 0) va = 300'({1'b1, a[22:0]}) << ea;
        if (eb != 0) vb = 300'({1'b1, b[22:0]}) << eb;
        if (sa == sb) begin mag = va + vb; s = sa; end
        else if (va >= vb) begin mag = va - vb; s = sa; end
        else begin mag = vb - va; s = sb; end
        if (mag == '0) return {rm == 2'b11, 31'd0, 2'b00};
        p = 0;
        for (int i = 0; i < 300; i++) if (mag[i]) p = i;
        e = p - 23;
        if (e < 1) return {s, 31'd0, 2'b01};
        keep = 25'((mag >> (p - 23)) & 300'hFFFFFF);
        g = mag[p - 24];
        low = mag & ((300'd1 << (p - 24)) - 300'd1);
        inexact = g | (low != '0);
        case (rm)
            2'b00: up = g & ((low != '0) | keep[0]);
            2'b01: up = 1'b0;
            2'b10: up = inexact & !s;
            default: up = inexact & s;
        endcase
        keep = keep + 25'(up);
        if (keep[24]) begin keep = keep >> 1; e = e + 1; end
        if (e >= 255) begin
            to_inf = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
            return to_inf ? {s, 8'hFF, 23'd0, 2'b10} : {s, 8'hFE, 23'h7FFFFF, 2'b10};
        end
        return {s, 8'(e), keep[22:0], 2'b00};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) exp_v[i] <= 1'b0;
        end else begin
            exp_v[0] <= in_vld;
            exp_r[0] <= ref_add(op_a, op_b, op_sub, in_rm);
            exp_t[0] <= cur_tag;
            for (int i = 1; i < 3; i++) begin
                exp_v[i] <= exp_v[i-1];
                exp_r[i] <= exp_r[i-1];
                exp_t[i] <= exp_t[i-1];
            end
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (out_vld !== exp_v[2]) begin
                fails++;
                $display("FAIL R1 out_vld: actual=%b expected=%b", out_vld, exp_v[2]);
            end else if (exp_v[2]) begin
                checks++;
                if ({result, ovf, unf} !== exp_r[2]) begin
                    fails++;
                    $display("FAIL %s: actual res=%h ovf=%b unf=%b expected res=%h ovf=%b unf=%b",
                             exp_t[2], result, ovf, unf, exp_r[2][33:2], exp_r[2][1], exp_r[2][0]);
                end
            end else begin
                checks++;
                if (ovf !== 1'b0 || unf !== 1'b0) begin
                    fails++;
                    $display("FAIL R1 idle flags: actual ovf=%b unf=%b expected 0 0", ovf, unf);
                end
            end
        end
    end

    task automatic issue(logic [31:0] a, logic [31:0] b, logic sub, logic [1:0] rm, string tag);
        @(negedge clk);
        in_vld = 1'b1; op_a = a; op_b = b; op_sub = sub; in_rm = rm; cur_tag = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    task automatic check_reset();
        checks++;
        if (out_vld !== 1'b0 || result !== 32'd0 || ovf !== 1'b0 || unf !== 1'b0) begin
            fails++;
            $display("FAIL R12: actual vld=%b res=%h ovf=%b unf=%b expected all zero",
                     out_vld, result, ovf, unf);
        end
    endtask

    function automatic logic [31:0] rand_op(logic [7:0] base, bit near);
        logic [31:0] v;
        int e;
        v = $urandom;
        if (near) begin
            e = int'(base) + int'($urandom_range(0, 6)) - 3;
            if (e < 1) e = 1;
            if (e > 254) e = 254;
            v[30:23] = 8'(e);
        end
        if (v[30:23] == 8'hFF) v[30:23] = 8'hFE;
        if (v[30:23] == 8'h00) v[30:23] = 8'h01;
        return v;
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        @(negedge clk);
        check_reset();

        issue(32'h3F800000, 32'h40000000, 1'b0, 2'b00, "R2");
        issue(32'h40A00000, 32'h3F800000, 1'b1, 2'b00, "R2");
        issue(32'h3F800000, 32'h40A00000, 1'b1, 2'b00, "R2");
        issue(32'hC0400000, 32'h3FC00000, 1'b0, 2'b01, "R2");
        issue(32'h3FC00000, 32'h3FC00000, 1'b0, 2'b00, "R5");
        issue(32'h3F800001, 32'h3F800000, 1'b1, 2'b00, "R6");
        issue(32'h4B000001, 32'h4AFFFFFF, 1'b1, 2'b00, "R6");
        issue(32'h3F800000, 32'h2B800000, 1'b0, 2'b10, "R4");
        issue(32'h3F800000, 32'h2B800000, 1'b0, 2'b00, "R4");
        issue(32'h3F800000, 32'h2B800000, 1'b1, 2'b01, "R4");
        issue(32'h3F800000, 32'h2B800000, 1'b1, 2'b11, "R4");
        for (int m = 0; m < 4; m++) begin
            issue(32'h3F800000, 32'h33C00000, 1'b0, 2'(m), "R3");
            issue(32'hBF800000, 32'hB3C00000, 1'b0, 2'(m), "R3");
            issue(32'h3F800000, 32'h33800000, 1'b0, 2'(m), "R3");
            issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'(m), "R8");
            issue(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 2'(m), "R8");
            issue(32'h3F800000, 32'h3F800000, 1'b1, 2'(m), "R10");
        end
        issue(32'h3FFFFFFF, 32'h33800000, 1'b0, 2'b10, "R7");
        issue(32'h3FFFFFFF, 32'h33800000, 1'b0, 2'b00, "R7");
        issue(32'h7F7FFFFF, 32'h73800000, 1'b0, 2'b10, "R8");
        issue(32'h7F7FFFFF, 32'h73800000, 1'b0, 2'b01, "R8");
        issue(32'h00800001, 32'h00800000, 1'b1, 2'b00, "R9");
        issue(32'h80800000, 32'h80800001, 1'b1, 2'b00, "R9");
        issue(32'h01000001, 32'h01000000, 1'b1, 2'b00, "R6");
        issue(32'h00000005, 32'h3F800000, 1'b0, 2'b00, "R11");
        issue(32'h00400000, 32'h00400000, 1'b0, 2'b00, "R11");
        issue(32'h00000000, 32'h00000000, 1'b0, 2'b11, "R10");
        idle(4);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            a = rand_op(8'd0, 1'b0);
            issue(a, rand_op(a[30:23], ($urandom_range(0, 3) != 0)), 1'($urandom), 2'($urandom), "R2");
            if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule